// File: doc/BRIEF.md
# Bang-Bang Early/Late Phase Detector

This block is the binary phase detector of a digital clock-and-data-recovery loop. Upstream samplers register three samples per bit: a data sample at the bit centre and edge samples at the bit boundaries. Once per bit, the block takes the current centre sample and the edge sample that lies between the previous bit and this one. It compares them with the previous data bit, which it keeps in its own register.

The block returns only a direction. It reports early (+1) or late (-1) as a 2-bit two's-complement value, and it never reports how large the error is. When the two neighbouring data bits are equal, the edge sample carries no timing information, so the block reports hold (0). A one-cycle valid strobe marks each evaluated bit. A downstream loop filter accumulates these votes into a phase correction.

An enable input selects which clock cycles carry a bit to evaluate. Cycles with the enable low produce hold with no valid strobe, and they leave the stored previous bit unchanged.

Top module: `bbpd_early_late`

## Requirements
- R1: After a synchronous active-high reset, `dir` is 00, `dir_vld` is 0, and the stored previous data bit is 0.
- R2: For an enabled bit whose data sample equals the stored previous data bit, the decision is hold, encoded 00, with `dir_vld` high.
- R3: For an enabled bit whose data sample differs from the stored previous bit, and whose edge sample equals the stored previous bit, the decision is early, encoded 01 (+1).
- R4: For an enabled bit whose data sample differs from the stored previous bit, and whose edge sample differs from the stored previous bit, the decision is late, encoded 11 (-1).
- R5: Each decision and its `dir_vld` appear exactly one rising clock edge after the samples are presented. `dir_vld` is high for one cycle per enabled bit.
- R6: In a cycle with `smp_en` low, the next cycle shows `dir` = 00 and `dir_vld` = 0, and the stored previous bit keeps its value.
- R7: On every enabled bit, the stored previous data bit takes the value of that bit's data sample.
- R8: The output only ever carries a sign. The code 10 never appears on `dir`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | High when the samples on this cycle form a bit to evaluate |
| edge_smp | input | 1 | Edge sample between the previous bit and the current bit |
| data_smp | input | 1 | Data sample at the centre of the current bit |
| dir | output | 2 | Two's-complement decision: 01 early, 11 late, 00 hold |
| dir_vld | output | 1 | High for one cycle with each evaluated decision |

## Verification
Every result of this block (the decision code, the valid strobe, and the effect of the stored previous bit) is due exactly one rising edge after the samples are driven. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so exactly one register stage lies between stimulus and check. The stored previous bit is not visible at the ports. The bench therefore tracks it in its own model, updates the model only on enabled bits, and observes the stored bit through the decision of the following enabled bit. An exhaustive sweep over previous bit, enable, edge sample and data sample is followed by a long pseudo-random stream and a reset taken mid-stream.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;
  localparam int DIR_W = 2;

  typedef enum logic [DIR_W-1:0] {
    DIR_HOLD  = 2'b00,
    DIR_EARLY = 2'b01,
    DIR_LATE  = 2'b11
  } dir_t;
endpackage

// File: rtl/bbpd_prev_bit.sv
module bbpd_prev_bit (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic data_smp,
  output logic prev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else if (smp_en) begin
      prev_q <= data_smp;
    end
  end

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> prev_q == $past(data_smp)); // R7
  AST_PREV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(prev_q)); // R6
endmodule

// File: rtl/bbpd_vote.sv
module bbpd_vote
  import bbpd_pkg::*;
(
  input  logic prev_bit,
  input  logic edge_bit,
  input  logic data_bit,
  output dir_t vote
);
  logic has_trans;

  always_comb begin
    has_trans = prev_bit ^ data_bit;
    if (!has_trans) begin
      vote = DIR_HOLD;
    end else if (edge_bit == prev_bit) begin
      vote = DIR_EARLY;
    end else begin
      vote = DIR_LATE;
    end
  end
endmodule

// File: rtl/bbpd_out_reg.sv
module bbpd_out_reg
  import bbpd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  dir_t             vote,
  output logic [DIR_W-1:0] dir_q,
  output logic             vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_HOLD;
      vld_q <= 1'b0;
    end else begin
      dir_q <= smp_en ? vote : DIR_HOLD;
      vld_q <= smp_en;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> (dir_q == 2'b00) && !vld_q); // R6
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> vld_q); // R5
  AST_NO_CODE_TWO: assert property (@(posedge clk) disable iff (rst)
    dir_q != 2'b10); // R8
endmodule

// File: rtl/bbpd_early_late.sv
module bbpd_early_late
  import bbpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       smp_en,
  input  logic       edge_smp,
  input  logic       data_smp,
  output logic [1:0] dir,
  output logic       dir_vld
);
  logic prev_q;
  dir_t vote;

  bbpd_prev_bit u_prev (
    .clk      (clk),
    .rst      (rst),
    .smp_en   (smp_en),
    .data_smp (data_smp),
    .prev_q   (prev_q)
  );

  bbpd_vote u_vote (
    .prev_bit (prev_q),
    .edge_bit (edge_smp),
    .data_bit (data_smp),
    .vote     (vote)
  );

  bbpd_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .smp_en (smp_en),
    .vote   (vote),
    .dir_q  (dir),
    .vld_q  (dir_vld)
  );

  AST_HOLD_NO_TRANS: assert property (@(posedge clk) disable iff (rst)
    (smp_en && (data_smp == prev_q)) |=> (dir == 2'b00) && dir_vld); // R2
  AST_EARLY_DIR: assert property (@(posedge clk) disable iff (rst)
    (smp_en && (data_smp != prev_q) && (edge_smp == prev_q)) |=> dir == 2'b01); // R3
  AST_LATE_DIR: assert property (@(posedge clk) disable iff (rst)
    (smp_en && (data_smp != prev_q) && (edge_smp != prev_q)) |=> dir == 2'b11); // R4
endmodule

// File: tb/test_bbpd_early_late.sv
module test_bbpd_early_late;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_en = 1'b0;
  logic       edge_smp = 1'b0;
  logic       data_smp = 1'b0;
  logic [1:0] dir;
  logic       dir_vld;

  int total = 0;
  int bad = 0;
  logic mprev = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  bbpd_early_late i_bbpd_early_late (
    .clk(clk), .rst(rst), .smp_en(smp_en), .edge_smp(edge_smp),
    .data_smp(data_smp), .dir(dir), .dir_vld(dir_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge; the result is due after one rising edge.
  task automatic step(input logic en, input logic e, input logic d);
    logic [1:0] exp_dir;
    string tag;
    smp_en = en; edge_smp = e; data_smp = d;
    if (!en) begin exp_dir = 2'b00; tag = "R6"; end
    else if (mprev == d) begin exp_dir = 2'b00; tag = "R2"; end
    else if (e == mprev) begin exp_dir = 2'b01; tag = "R3"; end
    else begin exp_dir = 2'b11; tag = "R4"; end
    @(posedge clk);
    @(negedge clk);
    chk(dir == exp_dir, tag, dir, exp_dir);
    chk(dir_vld == en, "R5", dir_vld, en);
    chk(dir != 2'b10, "R8", dir, 0);
    if (en) mprev = d; // R7: model of stored previous bit
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dir == 2'b00, "R1", dir, 0);
    chk(dir_vld == 1'b0, "R1", dir_vld, 0);
    rst = 1'b0;
    mprev = 1'b0;
  endtask

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    do_reset();
    // R1/R7: stored bit starts at 0, so data 1 with edge 0 is early
    step(1'b1, 1'b0, 1'b1);
    do_reset();
    step(1'b1, 1'b1, 1'b0); // R1: data equals reset value -> hold
    // Exhaustive sweep over prev, enable, edge, data
    for (int pv = 0; pv < 2; pv++) begin
      for (int c = 0; c < 8; c++) begin
        step(1'b1, 1'b0, pv[0]);
        step(c[2], c[1], c[0]);
        step(1'b1, 1'b1, ~mprev); // R6/R7: reveals stored bit via next decision
      end
    end
    // R5: enable held low for several cycles
    repeat (4) step(1'b0, 1'b1, 1'b1);
    // Pseudo-random stream
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[3], lfsr[1], lfsr[2]);
    end
    // Reset taken mid-stream
    step(1'b1, 1'b0, 1'b1);
    do_reset();
    step(1'b1, 1'b1, 1'b1); // R1: prev back to 0 -> late
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule